// File: doc/BRIEF.md
# ATA Register and Data Strobe Timing Generator

This block produces the host read and write strobes, both active low, for one device slot on a parallel ATA bus. A single 32-bit timing word carries two sets of intervals. One set is for task-file register accesses and the other is for PIO or multiword-DMA data transfers. Each set holds a setup time before the strobe, a strobe-active time and a strobe-inactive (recovery) time. Each interval lasts its field value plus one clock.

A one-clock start request launches one bus cycle. A read/write select and a command/data select qualify the request. The block holds both strobes high for the setup interval, drives the selected strobe low for the active interval, and then returns it high for the recovery interval. After that it raises `done` for one clock. `busy` marks the setup, active and recovery intervals. The timing word and both selects are captured when a cycle is accepted, so the controller above can reprogram them while a cycle runs. A start given in the `done` clock is accepted at once, which lets cycles run back to back with no idle gap.

Top module: `ata_strobe_timer`

## Requirements
- R1: While reset is asserted and after it is released, `dior_n` and `diow_n` are 1 and `busy` and `done` are 0.
- R2: With `cmd_sel` = 0 at acceptance, the setup interval lasts `timing_word[24:22]`+1 clocks, the strobe stays low for `timing_word[8:4]`+1 clocks, and the recovery lasts `timing_word[3:0]`+1 clocks.
- R3: With `cmd_sel` = 1 at acceptance, the setup interval lasts `timing_word[27:25]`+1 clocks, the strobe stays low for `timing_word[17:13]`+1 clocks, and the recovery lasts `timing_word[12:9]`+1 clocks.
- R4: `busy` rises on the clock edge that samples an accepted start. It stays high with both strobes high through setup, through the active interval and through recovery. While `busy` is low, both strobes are high.
- R5: `rd_sel` = 1 selects `dior_n` and `rd_sel` = 0 selects `diow_n`. Only the selected strobe goes low. The other strobe stays high for the whole cycle.
- R6: `done` is high for exactly one clock, starting on the edge that ends recovery. `busy` is low in that clock.
- R7: A start while `busy` is high is ignored. It neither adds a cycle nor alters the running cycle.
- R8: The timing word, `rd_sel` and `cmd_sel` are sampled on the accepting edge. Later changes to them do not affect the running cycle.
- R9: Bits 21:18 and 31:28 of the timing word have no effect on strobe timing.
- R10: A start in the `done` clock is accepted, so `busy` is high again in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| timing_word | input | 32 | Packed interval fields |
| start | input | 1 | One-clock request for a bus cycle |
| rd_sel | input | 1 | 1 = read strobe, 0 = write strobe |
| cmd_sel | input | 1 | 1 = task-file intervals, 0 = data intervals |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| busy | output | 1 | A cycle is in setup, active or recovery |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The end of one cycle (the `done` pulse) and the acceptance of the next request can fall in the same clock. The driver provokes this by waiting only for `busy` to drop, so a queued request lands exactly in the `done` clock. The scoreboard then requires that `done` was seen with `busy` low, and that the next cycle begins its setup interval in the following clock with its full measured length. A second collision places a fresh start, with a changed word and changed selects, inside a running cycle. It is judged by the unchanged interval lengths of that cycle and by the absence of any extra cycle.

// File: rtl/ats_pkg.sv
package ats_pkg;

  localparam int TW_WORD_W = 32;

  // data-transfer fields
  localparam int DAT_REC_LSB = 0;
  localparam int DAT_REC_W   = 4;
  localparam int DAT_ACT_LSB = 4;
  localparam int DAT_ACT_W   = 5;
  localparam int DAT_SET_LSB = 22;
  localparam int DAT_SET_W   = 3;
  // task-file fields
  localparam int CMD_REC_LSB = 9;
  localparam int CMD_REC_W   = 4;
  localparam int CMD_ACT_LSB = 13;
  localparam int CMD_ACT_W   = 5;
  localparam int CMD_SET_LSB = 25;
  localparam int CMD_SET_W   = 3;

  localparam int SET_W = DAT_SET_W;
  localparam int ACT_W = DAT_ACT_W;
  localparam int REC_W = DAT_REC_W;
  localparam int CNT_W = (ACT_W > REC_W) ? ((ACT_W > SET_W) ? ACT_W : SET_W)
                                        : ((REC_W > SET_W) ? REC_W : SET_W);

  typedef struct packed {
    logic [SET_W-1:0] setup;
    logic [ACT_W-1:0] active;
    logic [REC_W-1:0] recover;
  } ats_timing_t;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_ACTIVE  = 3'd2,
    ST_RECOVER = 3'd3,
    ST_DONE    = 3'd4
  } ats_state_e;

  typedef enum logic [1:0] {
    LD_SETUP   = 2'd0,
    LD_ACTIVE  = 2'd1,
    LD_RECOVER = 2'd2
  } ats_load_e;

  // Choose the interval set for a cycle from the packed word.
  function automatic ats_timing_t pick_timing(input logic [TW_WORD_W-1:0] w,
                                              input logic cmd);
    ats_timing_t t;
    if (cmd) begin
      t.setup   = w[CMD_SET_LSB +: CMD_SET_W];
      t.active  = w[CMD_ACT_LSB +: CMD_ACT_W];
      t.recover = w[CMD_REC_LSB +: CMD_REC_W];
    end else begin
      t.setup   = w[DAT_SET_LSB +: DAT_SET_W];
      t.active  = w[DAT_ACT_LSB +: DAT_ACT_W];
      t.recover = w[DAT_REC_LSB +: DAT_REC_W];
    end
    return t;
  endfunction

  function automatic logic state_busy(input ats_state_e s);
    return (s == ST_SETUP) || (s == ST_ACTIVE) || (s == ST_RECOVER);
  endfunction

endpackage

// File: rtl/ats_interval_counter.sv
module ats_interval_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/ats_snapshot.sv
module ats_snapshot
  import ats_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  ats_timing_t live_tm,
  input  logic        live_rd,
  output ats_timing_t snap_tm,
  output logic        snap_rd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_tm <= '0;
      snap_rd <= 1'b0;
    end else if (capture) begin
      snap_tm <= live_tm;
      snap_rd <= live_rd;
    end
  end
endmodule

// File: rtl/ats_sequencer.sv
module ats_sequencer
  import ats_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       expire,
  output ats_state_e state,
  output logic       accept,
  output logic       load_en,
  output ats_load_e  load_sel,
  output logic       busy,
  output logic       done
);
  ats_state_e nxt;

  always_comb begin
    nxt      = state;
    accept   = 1'b0;
    load_en  = 1'b0;
    load_sel = LD_SETUP;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          accept   = 1'b1;
          load_en  = 1'b1;
          load_sel = LD_SETUP;
          nxt      = ST_SETUP;
        end else begin
          nxt = ST_IDLE;
        end
      end
      ST_SETUP: begin
        if (expire) begin
          load_en  = 1'b1;
          load_sel = LD_ACTIVE;
          nxt      = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (expire) begin
          load_en  = 1'b1;
          load_sel = LD_RECOVER;
          nxt      = ST_RECOVER;
        end
      end
      ST_RECOVER: begin
        if (expire) nxt = ST_DONE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign busy = state_busy(state);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer
  import ats_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TW_WORD_W-1:0] timing_word,
  input  logic                 start,
  input  logic                 rd_sel,
  input  logic                 cmd_sel,
  output logic                 dior_n,
  output logic                 diow_n,
  output logic                 busy,
  output logic                 done
);
  localparam int N_STROBE = 2;

  ats_timing_t      live_tm;
  ats_timing_t      snap_tm;
  logic             snap_rd;
  logic             accept;
  logic             seg_expire;
  logic             load_en;
  ats_load_e        load_sel;
  ats_state_e       state;
  logic [CNT_W-1:0] load_val;
  logic [N_STROBE-1:0] strobe_n;

  assign live_tm = pick_timing(timing_word, cmd_sel);

  ats_sequencer seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .expire   (seg_expire),
    .state    (state),
    .accept   (accept),
    .load_en  (load_en),
    .load_sel (load_sel),
    .busy     (busy),
    .done     (done)
  );

  ats_snapshot snap_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (accept),
    .live_tm (live_tm),
    .live_rd (rd_sel),
    .snap_tm (snap_tm),
    .snap_rd (snap_rd)
  );

  // Setup is loaded in the accepting clock, before the snapshot is valid.
  always_comb begin
    case (load_sel)
      LD_ACTIVE:  load_val = CNT_W'(snap_tm.active);
      LD_RECOVER: load_val = CNT_W'(snap_tm.recover);
      default:    load_val = CNT_W'(live_tm.setup);
    endcase
  end

  ats_interval_counter #(.W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_en),
    .load_val (load_val),
    .expire   (seg_expire)
  );

  // index 0: write strobe, index 1: read strobe
  for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
    assign strobe_n[g] = !((state == ST_ACTIVE) && (snap_rd == (g == 1)));
  end

  assign diow_n = strobe_n[0];
  assign dior_n = strobe_n[1];
endmodule

// File: rtl/ats_checker.sv
module ats_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic dior_n,
  input logic diow_n,
  input logic seg_expire
);
  AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dior_n && diow_n)); // R4

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R4

  AST_NO_SPONTANEOUS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy); // R4

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n)); // R5

  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R6

  AST_BUSY_HELD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seg_expire) |=> busy); // R7

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> busy); // R10
endmodule

bind ata_strobe_timer ats_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .dior_n     (dior_n),
  .diow_n     (diow_n),
  .seg_expire (seg_expire)
);

// File: tb/ata_strobe_timer_tb_top.sv
`timescale 1ns/1ps
module ata_strobe_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] timing_word;
  logic        start;
  logic        rd_sel;
  logic        cmd_sel;
  logic        dior_n;
  logic        diow_n;
  logic        busy;
  logic        done;

  always #2.5 clk = ~clk;

  ata_strobe_timer dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .timing_word (timing_word),
    .start       (start),
    .rd_sel      (rd_sel),
    .cmd_sel     (cmd_sel),
    .dior_n      (dior_n),
    .diow_n      (diow_n),
    .busy        (busy),
    .done        (done)
  );

  typedef struct {
    int    setup_len;
    int    act_len;
    int    rec_len;
    bit    rd;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   phase    = 0;
  bit   mon_on   = 0;

  task automatic chk(input int got, input int want, input string what);
    n_checks++;
    if (got != want) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, got, want);
    end
  endtask

  // Expected lengths restated from R2/R3 (field value plus one clock).
  function automatic exp_t expect_of(input logic [31:0] w, input bit r,
                                     input bit c, input string tag);
    exp_t e;
    if (c) begin
      e.setup_len = int'((w >> 25) & 32'h7) + 1;
      e.act_len   = int'((w >> 13) & 32'h1f) + 1;
      e.rec_len   = int'((w >> 9) & 32'hf) + 1;
    end else begin
      e.setup_len = int'((w >> 22) & 32'h7) + 1;
      e.act_len   = int'((w >> 4) & 32'h1f) + 1;
      e.rec_len   = int'(w & 32'hf) + 1;
    end
    e.rd  = r;
    e.tag = tag;
    return e;
  endfunction

  // Driver: wait for busy low (idle or done clock), then pulse start.
  task automatic issue(input logic [31:0] w, input bit r, input bit c,
                       input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; timing_word = w; rd_sel = r; cmd_sel = c;
    q.push_back(expect_of(w, r, c, tag));
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: measure each cycle and compare with the queued expectation.
  initial begin
    exp_t cur;
    int   cnt = 0;
    bit   prev_done = 0;
    bit   sel_low, oth_low;
    cur = expect_of(32'h0, 1'b0, 1'b0, "none");
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (!dior_n && !diow_n) chk(1, 0, "R5 both strobes low");
        if (done && prev_done)  chk(1, 0, "R6 done wider than one clock");
        sel_low = cur.rd ? !dior_n : !diow_n;
        oth_low = cur.rd ? !diow_n : !dior_n;
        case (phase)
          0: begin
            if (busy) begin
              if (q.size() == 0) begin
                chk(1, 0, "R7 cycle without accepted request");
                cur = expect_of(32'h0, 1'b0, 1'b0, "none");
              end else begin
                cur = q.pop_front();
              end
              phase = 1; cnt = 1;
              if (!dior_n || !diow_n) chk(1, 0, "R4 strobe low in first setup clock");
            end else begin
              if (done) chk(1, 0, "R6 done outside a cycle");
              if (!dior_n || !diow_n) chk(1, 0, "R4 strobe low while idle");
            end
          end
          1: begin
            if (!busy) begin chk(0, 1, {cur.tag, " R4 busy dropped in setup"}); phase = 0; end
            else if (oth_low) begin chk(1, 0, "R5 wrong strobe driven"); phase = 0; end
            else if (sel_low) begin
              chk(cnt, cur.setup_len, {cur.tag, " setup length"});
              phase = 2; cnt = 1;
            end else cnt++;
          end
          2: begin
            if (!busy) begin chk(0, 1, {cur.tag, " R4 busy dropped in active"}); phase = 0; end
            else if (oth_low) begin chk(1, 0, "R5 wrong strobe driven"); phase = 0; end
            else if (sel_low) cnt++;
            else begin
              chk(cnt, cur.act_len, {cur.tag, " strobe low length"});
              phase = 3; cnt = 1;
            end
          end
          default: begin
            if (!busy) begin
              chk(int'(done), 1, "R6 done on recovery end");
              chk(cnt, cur.rec_len, {cur.tag, " recovery length"});
              phase = 0;
            end else if (sel_low || oth_low) begin
              chk(1, 0, "R4 strobe low in recovery"); phase = 0;
            end else cnt++;
          end
        endcase
      end
      prev_done = done;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; timing_word = '0; rd_sel = 1'b0; cmd_sel = 1'b0;
    idle(3);
    chk(int'(dior_n), 1, "R1 dior_n in reset");
    chk(int'(diow_n), 1, "R1 diow_n in reset");
    chk(int'(busy),   0, "R1 busy in reset");
    chk(int'(done),   0, "R1 done in reset");
    rst_n = 1'b1;
    idle(2);
    chk(int'(dior_n), 1, "R1 dior_n after reset");
    chk(int'(diow_n), 1, "R1 diow_n after reset");
    chk(int'(busy) + int'(done), 0, "R1 busy/done after reset");
    mon_on = 1'b1;

    // R2: data fields, read and write, zero and maximum values
    issue((32'd2 << 22) | (32'd5 << 4) | 32'd3, 1'b1, 1'b0, "R2 data read");
    idle(8);
    issue(32'h0, 1'b0, 1'b0, "R2 data zero write");
    idle(8);
    issue((32'd7 << 22) | (32'd31 << 4) | 32'd15, 1'b0, 1'b0, "R2 data max write");
    idle(6);

    // R3: task-file fields; data fields hold other values to tell them apart
    issue((32'd5 << 25) | (32'd9 << 13) | (32'd7 << 9) | (32'd1 << 22) | (32'd2 << 4) | 32'd1,
          1'b1, 1'b0 | 1'b1, "R3 cmd read");
    idle(5);
    issue((32'd7 << 25) | (32'd31 << 13) | (32'd15 << 9), 1'b0, 1'b1, "R3 cmd max write");
    idle(5);
    issue(32'h0000_0000, 1'b1, 1'b1, "R3 cmd zero read");
    idle(5);

    // R9: UDMA field and control bits set
    issue(32'hF03C_0000 | (32'd3 << 22) | (32'd4 << 4) | 32'd2, 1'b1, 1'b0, "R9 data");
    idle(4);
    issue(32'hF03C_0000 | (32'd1 << 25) | (32'd6 << 13) | (32'd3 << 9), 1'b0, 1'b1, "R9 cmd");
    idle(4);

    // R10: back-to-back, each start lands in the done clock
    issue((32'd1 << 22) | (32'd2 << 4) | 32'd0, 1'b1, 1'b0, "R10 first");
    issue((32'd0 << 25) | (32'd3 << 13) | (32'd2 << 9), 1'b0, 1'b1, "R10 second");
    issue(32'h0, 1'b1, 1'b0, "R10 third");
    issue((32'd4 << 22) | (32'd1 << 4) | 32'd5, 1'b0, 1'b0, "R10 fourth");
    idle(6);

    // R7 and R8: new start, word and selects while a cycle runs
    issue((32'd3 << 22) | (32'd10 << 4) | 32'd6, 1'b1, 1'b0, "R7 R8 data read");
    idle(2);
    timing_word = 32'hFFFF_FFFF; rd_sel = 1'b0; cmd_sel = 1'b1; start = 1'b1;
    idle(3);
    start = 1'b0;
    idle(4);
    timing_word = 32'h0; rd_sel = 1'b0;
    idle(30);
    chk(int'(busy), 0, "R7 no cycle from ignored start");
    issue((32'd2 << 25) | (32'd4 << 13) | (32'd3 << 9), 1'b0, 1'b1, "R8 cmd write");
    idle(1);
    timing_word = 32'h0; cmd_sel = 1'b0; rd_sel = 1'b1;
    idle(30);

    chk(q.size(), 0, "R7 all requests completed");
    chk(phase, 0, "R6 last cycle closed with done");
    chk(int'(busy), 0, "R7 bus idle at end");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule